// File: doc/BRIEF.md
# Mode-Aliased Floating-Point Register File

This block is the storage of a floating-point unit. It has thirty-two 64-bit entries, two registered read ports and one write port. Each access carries a 5-bit index and a size select for a 32-bit or a 64-bit transfer. A global mode input decides how an index reaches storage. With the mode set, each index owns a full 64-bit entry. With the mode clear, the 32-bit registers live in pairs. An odd index then names the upper word of its even neighbour, and a 64-bit access always lands on the even entry of the pair.

The read ports also serve moves to the 64-bit integer register file. When a read is flagged as an integer transfer, a 32-bit word is sign-extended to 64 bits. Without the flag, the word comes back zero-extended. The write port also serves moves from the integer side and loads. A 32-bit write updates only the four bytes of the selected lane. The rest of the entry keeps its value.

Top module: `fpr_bank`

## Requirements
- R1: With `wide_mode`=1, index i selects entry i. A 32-bit access (size select 0) uses bits [31:0] of that entry.
- R2: With `wide_mode`=0, a 32-bit access to an even index i uses bits [31:0] of entry i.
- R3: With `wide_mode`=0, a 32-bit access to an odd index i uses bits [63:32] of entry i-1.
- R4: With `wide_mode`=0, a 64-bit access (size select 1) to index i uses all of entry i with bit 0 cleared, whatever bit 0 holds. This applies to reads and to writes.
- R5: A 32-bit read with the integer-transfer flag set returns the word sign-extended to 64 bits. With the flag clear, bits [63:32] read as zero. A 64-bit read returns the entry unchanged in either case.
- R6: A 32-bit write takes `wr_data[31:0]` into the selected lane only. The other half of that entry and every other entry are left unchanged.
- R7: A read presented in the same cycle as a write to the same location returns the value from before the write. The new value is visible to a read in the next cycle.
- R8: Reset clears every entry and both read outputs to zero.
- R9: A read port whose enable is low holds its previous output, even while its index changes.
- R10: With `wr_en` low, no entry changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wide_mode | input | 1 | 1: every index owns an entry; 0: 32-bit registers paired |
| rd_en | input | 2 | Per read port: sample a new read |
| rd_wide | input | 2 | Per read port: 1 = 64-bit, 0 = 32-bit |
| rd_sext | input | 2 | Per read port: 1 = integer transfer, sign-extend a 32-bit word |
| rd_idx | input | 2x5 | Per read port: register index |
| rd_data | output | 2x64 | Per read port: registered read result |
| wr_en | input | 1 | Write enable |
| wr_wide | input | 1 | 1 = 64-bit write, 0 = 32-bit write |
| wr_idx | input | 5 | Write index |
| wr_data | input | 64 | Write data; only bits [31:0] are used for a 32-bit write |

## Verification
A wrong index mapping or a wrong lane select stores a word in the wrong place. This stays hidden until that location is read, so the bench fills every index in each mode and size, then reads every index back through both ports in every form. A write mask that is too wide corrupts the neighbouring half. This shows up on the first 64-bit read of that entry, one cycle after the read request. An extension fault or a hold fault shows in the upper bits on the cycle right after the read edge.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    // Transfer size of one access
    typedef enum logic {
        XFER_W32 = 1'b0,
        XFER_W64 = 1'b1
    } xfer_size_e;

    // Where an access lands after index mapping, minus the entry number
    typedef struct packed {
        logic       hi;    // upper 32-bit lane selected
        xfer_size_e size;
    } lane_sel_t;

endpackage

// File: rtl/fpr_map.sv
module fpr_map
    import fpr_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             wide_mode,
    input  xfer_size_e       size,
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] entry,
    output lane_sel_t        lane
);

    // Paired mode folds odd indices onto the even entry. Only narrow
    // accesses to an odd index pick the upper lane.
    always_comb begin
        entry     = idx;
        lane.size = size;
        lane.hi   = 1'b0;
        if (!wide_mode) begin
            entry[0] = 1'b0;
            lane.hi  = (size == XFER_W32) && idx[0];
        end
    end

endmodule

// File: rtl/fpr_wmask.sv
module fpr_wmask
    import fpr_pkg::*;
#(
    parameter  int ENTRIES = 32,
    parameter  int DATA_W  = 64,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int BYTES   = DATA_W / 8,
    localparam int HB      = BYTES / 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            en,
    input  logic [IDX_W-1:0]                entry,
    input  lane_sel_t                       lane,
    output logic [ENTRIES-1:0][BYTES-1:0]   byte_en
);

    logic [BYTES-1:0] lane_bytes;

    always_comb begin
        if (lane.size == XFER_W64) begin
            lane_bytes = '1;
        end else if (lane.hi) begin
            lane_bytes = {{HB{1'b1}}, {HB{1'b0}}};
        end else begin
            lane_bytes = {{HB{1'b0}}, {HB{1'b1}}};
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        assign byte_en[e] = (en && (entry == IDX_W'(e))) ? lane_bytes : '0;
    end

    // R6: a narrow write touches exactly half an entry
    assert_half_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && lane.size == XFER_W32) |-> ($countones(byte_en) == HB));

    // R4: a full write touches exactly one whole entry
    assert_full_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && lane.size == XFER_W64) |-> ($countones(byte_en) == BYTES));

    // R10: no byte enabled while idle
    assert_idle_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> ($countones(byte_en) == 0));

endmodule

// File: rtl/fpr_rdport.sv
module fpr_rdport
    import fpr_pkg::*;
#(
    parameter  int ENTRIES = 32,
    parameter  int DATA_W  = 64,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int HALF_W  = DATA_W / 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            en,
    input  logic                            sext,
    input  logic [IDX_W-1:0]                entry,
    input  lane_sel_t                       lane,
    input  logic [ENTRIES-1:0][DATA_W-1:0]  cells,
    output logic [DATA_W-1:0]               data
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [DATA_W-1:0] word;
    logic [HALF_W-1:0] half;

    always_comb begin
        st_d = st_q;
        word = cells[entry];
        half = lane.hi ? word[DATA_W-1:HALF_W] : word[HALF_W-1:0];
        if (en) begin
            if (lane.size == XFER_W64) begin
                st_d.data = word;
            end else if (sext) begin
                st_d.data = {{HALF_W{half[HALF_W-1]}}, half};
            end else begin
                st_d.data = {{HALF_W{1'b0}}, half};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data = st_q.data;

    // R9: an idle port keeps its result
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(data));

    // R5: integer transfer of a word is sign-extended
    assert_sext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sext && lane.size == XFER_W32) |=>
            (data[DATA_W-1:HALF_W] == {HALF_W{data[HALF_W-1]}}));

    // R5: plain narrow read is zero-extended
    assert_zext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sext && lane.size == XFER_W32) |=> (data[DATA_W-1:HALF_W] == '0));

endmodule

// File: rtl/fpr_bank.sv
module fpr_bank
    import fpr_pkg::*;
#(
    parameter  int ENTRIES  = 32,
    parameter  int DATA_W   = 64,
    parameter  int RD_PORTS = 2,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wide_mode,
    input  logic [RD_PORTS-1:0]               rd_en,
    input  logic [RD_PORTS-1:0]               rd_wide,
    input  logic [RD_PORTS-1:0]               rd_sext,
    input  logic [RD_PORTS-1:0][IDX_W-1:0]    rd_idx,
    output logic [RD_PORTS-1:0][DATA_W-1:0]   rd_data,
    input  logic                              wr_en,
    input  logic                              wr_wide,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [DATA_W-1:0]                 wr_data
);

    localparam int BYTES  = DATA_W / 8;
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [ENTRIES-1:0][DATA_W-1:0] cells;
    } bank_state_t;

    bank_state_t st_d, st_q;

    // ---------------- write path ----------------
    logic [IDX_W-1:0]              wr_entry;
    lane_sel_t                     wr_lane;
    logic [ENTRIES-1:0][BYTES-1:0] wr_be;
    logic [DATA_W-1:0]             wr_lane_data;

    fpr_map #(.IDX_W(IDX_W)) wr_map_i (
        .wide_mode (wide_mode),
        .size      (xfer_size_e'(wr_wide)),
        .idx       (wr_idx),
        .entry     (wr_entry),
        .lane      (wr_lane)
    );

    fpr_wmask #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) wr_mask_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (wr_en),
        .entry   (wr_entry),
        .lane    (wr_lane),
        .byte_en (wr_be)
    );

    // A narrow word is presented on both lanes; the byte mask picks one.
    assign wr_lane_data = wr_wide ? wr_data
                                  : {wr_data[HALF_W-1:0], wr_data[HALF_W-1:0]};

    always_comb begin
        st_d = st_q;
        for (int e = 0; e < ENTRIES; e++) begin
            for (int b = 0; b < BYTES; b++) begin
                if (wr_be[e][b]) begin
                    st_d.cells[e][b*8 +: 8] = wr_lane_data[b*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- read ports ----------------
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        logic [IDX_W-1:0] rd_entry;
        lane_sel_t        rd_lane;

        fpr_map #(.IDX_W(IDX_W)) rd_map_i (
            .wide_mode (wide_mode),
            .size      (xfer_size_e'(rd_wide[p])),
            .idx       (rd_idx[p]),
            .entry     (rd_entry),
            .lane      (rd_lane)
        );

        fpr_rdport #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) rd_port_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (rd_en[p]),
            .sext  (rd_sext[p]),
            .entry (rd_entry),
            .lane  (rd_lane),
            .cells (st_q.cells),
            .data  (rd_data[p])
        );
    end

    // R8: first cycle out of reset sees cleared storage and outputs
    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((st_q == '0) && (rd_data == '0)));

    // R10: storage is frozen while the write port is idle
    assert_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q));

endmodule

// File: tb/fpr_bank_tb.sv
module fpr_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wide_mode = 1'b1;
    logic [1:0]       rd_en = '0;
    logic [1:0]       rd_wide = '0;
    logic [1:0]       rd_sext = '0;
    logic [1:0][4:0]  rd_idx = '0;
    logic [1:0][63:0] rd_data;
    logic             wr_en = 1'b0;
    logic             wr_wide = 1'b0;
    logic [4:0]       wr_idx = '0;
    logic [63:0]      wr_data = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [63:0] mdl [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    fpr_bank dut_i (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
        .rd_en(rd_en), .rd_wide(rd_wide), .rd_sext(rd_sext),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_wide(wr_wide), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    // ---------- reference model from the requirements ----------
    function automatic int phys(bit m, int i);
        return m ? i : i - (i % 2);
    endfunction

    function automatic bit upper(bit m, bit w, int i);
        return !m && !w && (i % 2 == 1);
    endfunction

    function automatic logic [63:0] exp_rd(bit w, bit s, int i);
        logic [63:0] v;
        logic [31:0] h;
        v = mdl[phys(wide_mode, i)];
        if (w) return v;
        h = upper(wide_mode, w, i) ? v[63:32] : v[31:0];
        return s ? {{32{h[31]}}, h} : {32'h0, h};
    endfunction

    function automatic void mdl_wr(bit w, int i, logic [63:0] d);
        int e;
        e = phys(wide_mode, i);
        if (w) mdl[e] = d;
        else if (upper(wide_mode, w, i)) mdl[e][63:32] = d[31:0];
        else mdl[e][31:0] = d[31:0];
    endfunction

    function automatic string tg(bit w, int i);
        if (wide_mode) return "R1";
        if (w) return "R4";
        return (i % 2 == 1) ? "R3" : "R2";
    endfunction

    function automatic logic [63:0] pat(int i, int k);
        return 64'h9E37_79B9_7F4A_7C15 * 64'(i + 1 + k * 33) ^ 64'(k);
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------- stimulus tasks (inputs change at negedge) ----------
    task automatic wr(bit w, int i, logic [63:0] d);
        wr_en = 1'b1; wr_wide = w; wr_idx = 5'(i); wr_data = d;
        @(negedge clk);
        mdl_wr(w, i, d);
        wr_en = 1'b0;
    endtask

    task automatic rd_pair(int ia, bit wa, bit sa, int ib, bit wb, bit sb,
                           string ta, string tb);
        logic [63:0] ea, eb;
        ea = exp_rd(wa, sa, ia);
        eb = exp_rd(wb, sb, ib);
        rd_en = 2'b11;
        rd_wide = {wb, wa}; rd_sext = {sb, sa};
        rd_idx[0] = 5'(ia); rd_idx[1] = 5'(ib);
        @(negedge clk);
        rd_en = 2'b00;
        check(ta, rd_data[0], ea);
        check(tb, rd_data[1], eb);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] old_a, old_b, held;
        for (int i = 0; i < N; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: every entry reads zero after reset
        check("R8", rd_data[0], 64'h0);
        check("R8", rd_data[1], 64'h0);
        wide_mode = 1'b1;
        for (int i = 0; i < N; i++)
            rd_pair(i, 1, 0, N-1-i, 1, 1, "R8", "R8");

        // R1: full writes in wide mode, read back in every form
        for (int i = 0; i < N; i++) wr(1, i, pat(i, 1));
        for (int i = 0; i < N; i++)
            rd_pair(i, 1, 0, i, 0, i % 2, "R1", "R1");

        // R6: narrow writes in wide mode leave upper halves intact
        for (int i = 1; i < N; i += 2) wr(0, i, pat(i, 2));
        for (int i = 0; i < N; i++)
            rd_pair(i, 1, 0, i, 0, 1, "R6", "R1");

        // R2 / R3 / R6: paired mode, narrow writes to every index
        wide_mode = 1'b0;
        for (int i = 0; i < N; i++) wr(0, i, pat(i, 3));
        for (int i = 0; i < N; i++)
            rd_pair(i, 0, 1, i, 0, 0, tg(0, i), tg(0, i));
        for (int i = 0; i < N; i++)
            rd_pair(i, 1, 0, i ^ 1, 0, 0, "R6", tg(0, i ^ 1));

        // R4: full writes via odd indices land on the even entry
        for (int i = 1; i < N; i += 4) wr(1, i, pat(i, 4));
        for (int i = 0; i < N; i++)
            rd_pair(i, 1, 0, i ^ 1, 1, 1, "R4", "R4");
        wide_mode = 1'b1;
        for (int i = 0; i < N; i += 2)
            rd_pair(i, 1, 0, i + 1, 1, 0, "R4", "R1");

        // R5: sign and zero extension of narrow reads
        wide_mode = 1'b0;
        wr(0, 9, 64'hDEAD_BEEF_8000_1234);
        wr(0, 8, 64'h1111_1111_7FFF_0001);
        rd_pair(9, 0, 1, 9, 0, 0, "R5", "R5");
        check("R5", rd_data[0], 64'hFFFF_FFFF_8000_1234);
        check("R5", rd_data[1], 64'h0000_0000_8000_1234);
        rd_pair(8, 0, 1, 8, 1, 1, "R5", "R5");
        check("R5", rd_data[0], 64'h0000_0000_7FFF_0001);
        check("R5", rd_data[1], 64'h8000_1234_7FFF_0001);

        // R7: read in the write cycle returns the old value
        old_a = exp_rd(1, 0, 6);
        old_b = exp_rd(0, 0, 7);
        wr_en = 1'b1; wr_wide = 1'b0; wr_idx = 5'd7; wr_data = 64'h0BAD_F00D_CAFE_0777;
        rd_en = 2'b11; rd_wide = 2'b01; rd_sext = 2'b00;
        rd_idx[0] = 5'd6; rd_idx[1] = 5'd7;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 2'b00;
        mdl_wr(0, 7, 64'h0BAD_F00D_CAFE_0777);
        check("R7", rd_data[0], old_a);
        check("R7", rd_data[1], old_b);
        rd_pair(6, 1, 0, 7, 0, 0, "R7", "R7");
        check("R7", rd_data[1], 64'h0000_0000_CAFE_0777);

        // R9: idle read ports hold their output
        rd_pair(3, 1, 0, 12, 0, 1, "R9", "R9");
        held = rd_data[0];
        old_b = rd_data[1];
        rd_en = 2'b00; rd_idx[0] = 5'd20; rd_idx[1] = 5'd21; rd_wide = 2'b10;
        repeat (2) @(negedge clk);
        check("R9", rd_data[0], held);
        check("R9", rd_data[1], old_b);

        // R10: disabled write changes nothing
        wr_en = 1'b0; wr_wide = 1'b1; wr_idx = 5'd4; wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        wr_wide = 1'b0; wr_idx = 5'd5;
        @(negedge clk);
        rd_pair(4, 1, 0, 5, 0, 0, "R10", "R10");
        wide_mode = 1'b1;
        for (int i = 0; i < N; i++)
            rd_pair(i, 1, 0, i, 0, 1, "R10", "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule